// File: doc/BRIEF.md
# Vector Floating-Point Min/Max Reduction Unit

This unit folds the elements of one vector source group into a single floating-point value and takes the largest or the smallest. The caller decodes the instruction fields and presents them with a single-cycle `start` pulse: the 6-bit function code, the mask-enable bit, the element width code, the vector length, the element mask, and a scalar seed. The seed is element 0 of the second source operand. The unit loads its accumulator from the seed. It then asks for source elements by index, lowest first, and takes one element in each cycle in which the caller raises `elem_valid`. Each active element is compared with the accumulator, and the winner is kept.

On completion the unit pulses `done` for one cycle. When the operation actually ran, it also raises `wr_en`, which writes `result` into element 0 of the destination and nowhere else, and `vstart_clr`, which resets the vector start index. Some operations are refused in the start cycle and end in the next cycle with no write: function codes the unit does not know, element widths that are not allowed, sum reductions (there is no floating-point adder in the unit), and a zero vector length. Only 16-bit and 32-bit IEEE-754 binary formats are compared.

Top module: `fp_vec_reduce`

## Requirements
- R1: The `funct6` input is decoded as follows: 000111 selects maximum, 000101 selects minimum, 000011 and 000001 select sum, 110011 and 110001 select widening sum. Any other code raises `illegal` together with `done`, one cycle after `start`.
- R2: The `sew` code means 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit. Code 0 is illegal for every operation. A widening sum with code 3 is illegal. An illegal operation never raises `wr_en` or `vstart_clr`.
- R3: A legal operation that is either a sum (plain or widening) or a min/max at width code 3 raises `unsup` with `done`, one cycle after `start`, and does not write. `illegal` takes precedence over `unsup`, and the two are never raised together.
- R4: A legal min/max with `vl` = 0 raises `done` one cycle after `start`, with `wr_en`, `vstart_clr`, `illegal` and `unsup` all low, and requests no element.
- R5: The accumulator starts from `seed`. At 16-bit width only `seed[15:0]` is used, and `result[31:16]` reads zero.
- R6: Elements are requested through `elem_idx` in ascending order from 0 to `vl`-1. The index moves on by one in each busy cycle in which `elem_valid` is high. With `vm` = 1 every element is active. With `vm` = 0 only element i with `mask[i]` = 1 is active. Inactive elements leave the accumulator unchanged, so an all-inactive run returns the seed.
- R7: Ordering follows the floating-point value, with -0 below +0. A NaN (all exponent bits set and a nonzero fraction) compared with a number yields the number. Two NaNs yield the canonical quiet NaN: 16'h7E00 at 16-bit width, 32'h7FC00000 at 32-bit width.
- R8: After the last element is accepted, `done`, `wr_en` and `vstart_clr` rise in the next cycle and last exactly one cycle. `result` holds the reduction during that cycle. After reset `done`, `wr_en` and `busy` are low.
- R9: `busy` is high from the cycle after an accepted `start` through the `done` cycle. A `start` seen while `busy` is high is ignored, including one in the `done` cycle. `elem_valid` has no effect while the unit is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Accept a new operation when idle |
| funct6 | input | 6 | Reduction function code |
| vm | input | 1 | 1 = unmasked, 0 = use `mask` |
| sew | input | 2 | Element width code |
| vl | input | VL_W (6) | Vector length, 0 to MAX_ELEM |
| mask | input | MAX_ELEM (32) | Per-element active bits |
| seed | input | 32 | Element 0 of the scalar source |
| elem_valid | input | 1 | `elem_data` holds element `elem_idx` |
| elem_data | input | 32 | Source element value |
| elem_idx | output | IDX_W (5) | Index of the element requested |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |
| illegal | output | 1 | Operation refused as illegal, with `done` |
| unsup | output | 1 | Legal but not computed, with `done` |
| wr_en | output | 1 | Write `result` to destination element 0 |
| vstart_clr | output | 1 | Clear the vector start index |
| result | output | 32 | Reduced value |

## Verification
Two events can land in the same cycle: a fresh `start` and the `done` pulse of the operation still in flight. The bench raises `start` in exactly the `done` cycle, with a different legal operation. It then checks on the next cycle that `busy` and `done` are both low, so the second request was dropped. After that it pulses `elem_valid` while the unit is idle and confirms that no completion follows. Random runs with gaps in `elem_valid`, random masks, signed zeros and NaNs are compared with a bench model of the fold, which uses sign-magnitude comparison.

// File: rtl/fpred_pkg.sv
package fpred_pkg;

    localparam int ELEM_W = 32;
    localparam int HALF_W = 16;

    localparam logic [5:0] F6_OSUM  = 6'b000011;
    localparam logic [5:0] F6_USUM  = 6'b000001;
    localparam logic [5:0] F6_MAX   = 6'b000111;
    localparam logic [5:0] F6_MIN   = 6'b000101;
    localparam logic [5:0] F6_WOSUM = 6'b110011;
    localparam logic [5:0] F6_WUSUM = 6'b110001;

    typedef enum logic [2:0] {
        OP_OSUM, OP_USUM, OP_MAX, OP_MIN, OP_WOSUM, OP_WUSUM, OP_BAD
    } red_op_e;

    typedef enum logic [1:0] {
        SEW_8 = 2'd0, SEW_16 = 2'd1, SEW_32 = 2'd2, SEW_64 = 2'd3
    } sew_e;

    typedef enum logic [1:0] {
        ST_IDLE, ST_RUN, ST_FIN
    } state_e;

    // decoded request handed to the sequencer
    typedef struct packed {
        logic illegal;
        logic unsup;
        logic is_max;
        logic fmt16;
    } dec_t;

    // outcome latched at start, released with done
    typedef struct packed {
        logic illegal;
        logic unsup;
        logic wr;
    } outcome_t;

    function automatic red_op_e f6_to_op(input logic [5:0] f6);
        red_op_e op;
        case (f6)
            F6_OSUM:  op = OP_OSUM;
            F6_USUM:  op = OP_USUM;
            F6_MAX:   op = OP_MAX;
            F6_MIN:   op = OP_MIN;
            F6_WOSUM: op = OP_WOSUM;
            F6_WUSUM: op = OP_WUSUM;
            default:  op = OP_BAD;
        endcase
        return op;
    endfunction

    function automatic logic [ELEM_W-1:0] size_to_fmt(input logic [ELEM_W-1:0] v,
                                                        input logic fmt16);
        return fmt16 ? {{(ELEM_W-HALF_W){1'b0}}, v[HALF_W-1:0]} : v;
    endfunction

endpackage

// File: rtl/fpred_decode.sv
module fpred_decode
    import fpred_pkg::*;
(
    input  logic [5:0] funct6,
    input  logic [1:0] sew,
    output dec_t       dec
);

    red_op_e op;
    logic    widen;
    logic    is_sum;
    logic    bad_width;
    logic    ill;

    always_comb begin
        op        = f6_to_op(funct6);
        widen     = (op == OP_WOSUM) || (op == OP_WUSUM);
        is_sum    = widen || (op == OP_OSUM) || (op == OP_USUM);
        bad_width = (sew_e'(sew) == SEW_8) || (widen && (sew_e'(sew) == SEW_64));
        ill       = (op == OP_BAD) || bad_width;
    end

    always_comb begin
        dec.illegal = ill;
        dec.unsup   = !ill && (is_sum || (sew_e'(sew) == SEW_64));
        dec.is_max  = (op == OP_MAX);
        dec.fmt16   = (sew_e'(sew) == SEW_16);
    end

endmodule

// File: rtl/fpred_cmp.sv
module fpred_cmp
    import fpred_pkg::*;
(
    input  logic [ELEM_W-1:0] acc,
    input  logic [ELEM_W-1:0] elem,
    input  logic              fmt16,
    input  logic              is_max,
    output logic [ELEM_W-1:0] pick
);

    logic [1:0][ELEM_W-1:0] res;

    for (genvar g = 0; g < 2; g++) begin : g_fmt
        localparam int W  = (g == 0) ? HALF_W : ELEM_W;
        localparam int EW = (g == 0) ? 5 : 8;
        localparam int MW = W - 1 - EW;
        localparam logic [W-1:0] CANON = {1'b0, {EW{1'b1}}, 1'b1, {(MW-1){1'b0}}};

        logic [W-1:0] a, b, ka, kb, y;
        logic         na, nb, b_wins;

        assign a  = acc[W-1:0];
        assign b  = elem[W-1:0];
        assign na = (&a[W-2:MW]) && (|a[MW-1:0]);
        assign nb = (&b[W-2:MW]) && (|b[MW-1:0]);
        // sign-magnitude mapped onto an unsigned order; -0 lands below +0
        assign ka = a[W-1] ? ~a : {1'b1, a[W-2:0]};
        assign kb = b[W-1] ? ~b : {1'b1, b[W-2:0]};
        assign b_wins = is_max ? (kb > ka) : (kb < ka);

        always_comb begin
            if (na && nb)      y = CANON;
            else if (na)       y = b;
            else if (nb)       y = a;
            else if (b_wins)   y = b;
            else               y = a;
        end

        assign res[g] = ELEM_W'(y);
    end

    assign pick = fmt16 ? res[0] : res[1];

endmodule

// File: rtl/fpred_ctrl.sv
module fpred_ctrl
    import fpred_pkg::*;
#(
    parameter int MAX_ELEM = 32,
    parameter int VL_W     = $clog2(MAX_ELEM + 1),
    parameter int IDX_W    = $clog2(MAX_ELEM)
)(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  dec_t                dec,
    input  logic                vm,
    input  logic [MAX_ELEM-1:0] mask,
    input  logic [VL_W-1:0]     vl,
    input  logic [ELEM_W-1:0]   seed,
    input  logic                elem_valid,
    input  logic [ELEM_W-1:0]   fold_y,
    output logic [IDX_W-1:0]    elem_idx,
    output logic [ELEM_W-1:0]   acc_o,
    output logic                fmt16_o,
    output logic                is_max_o,
    output logic                busy,
    output logic                done,
    output logic                illegal,
    output logic                unsup,
    output logic                wr_en,
    output logic                vstart_clr
);

    state_e                st;
    logic [IDX_W-1:0]      idx;
    logic [VL_W-1:0]       vl_q;
    logic [MAX_ELEM-1:0]   mask_q;
    logic                  vm_q;
    logic                  fmt16_q;
    logic                  is_max_q;
    outcome_t              oc_q;
    logic [ELEM_W-1:0]     acc;

    logic accept, quick, step, active, last;

    assign accept = (st == ST_IDLE) && start;
    assign quick  = dec.illegal || dec.unsup || (vl == '0);
    assign step   = (st == ST_RUN) && elem_valid;
    assign active = vm_q || mask_q[idx];
    assign last   = (VL_W'(idx) + VL_W'(1)) == vl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            idx      <= '0;
            vl_q     <= '0;
            mask_q   <= '0;
            vm_q     <= 1'b0;
            fmt16_q  <= 1'b0;
            is_max_q <= 1'b0;
            oc_q     <= '0;
            acc      <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        vl_q     <= vl;
                        mask_q   <= mask;
                        vm_q     <= vm;
                        fmt16_q  <= dec.fmt16;
                        is_max_q <= dec.is_max;
                        acc      <= size_to_fmt(seed, dec.fmt16);
                        idx      <= '0;
                        oc_q     <= '{illegal: dec.illegal, unsup: dec.unsup, wr: !quick};
                        st       <= quick ? ST_FIN : ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (elem_valid) begin
                        if (active) acc <= fold_y;
                        if (last) st  <= ST_FIN;
                        else      idx <= idx + IDX_W'(1);
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign elem_idx   = idx;
    assign acc_o      = acc;
    assign fmt16_o    = fmt16_q;
    assign is_max_o   = is_max_q;
    assign busy       = (st != ST_IDLE);
    assign done       = (st == ST_FIN);
    assign illegal    = done && oc_q.illegal;
    assign unsup      = done && oc_q.unsup;
    assign wr_en      = done && oc_q.wr;
    assign vstart_clr = done && oc_q.wr;

    AST_SEED_LOAD: assert property (@(posedge clk) disable iff (rst)
        accept |=> acc_o == size_to_fmt($past(seed), $past(dec.fmt16))); // R5

    AST_MASKED_HOLD: assert property (@(posedge clk) disable iff (rst)
        step && !active |=> $stable(acc_o)); // R6

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN) |-> (VL_W'(elem_idx) < vl_q)); // R6

    AST_QUICK_DONE: assert property (@(posedge clk) disable iff (rst)
        accept && quick |=> done && !wr_en); // R4

    AST_ILL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        illegal |-> !wr_en && !vstart_clr && !unsup); // R2

    AST_LAST_FINISH: assert property (@(posedge clk) disable iff (rst)
        step && last |=> done && wr_en); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8

    AST_START_DROPPED: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy); // R9

endmodule

// File: rtl/fp_vec_reduce.sv
module fp_vec_reduce
    import fpred_pkg::*;
#(
    parameter int MAX_ELEM = 32,
    parameter int VL_W     = $clog2(MAX_ELEM + 1),
    parameter int IDX_W    = $clog2(MAX_ELEM)
)(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [5:0]          funct6,
    input  logic                vm,
    input  logic [1:0]          sew,
    input  logic [VL_W-1:0]     vl,
    input  logic [MAX_ELEM-1:0] mask,
    input  logic [ELEM_W-1:0]   seed,
    input  logic                elem_valid,
    input  logic [ELEM_W-1:0]   elem_data,
    output logic [IDX_W-1:0]    elem_idx,
    output logic                busy,
    output logic                done,
    output logic                illegal,
    output logic                unsup,
    output logic                wr_en,
    output logic                vstart_clr,
    output logic [ELEM_W-1:0]   result
);

    dec_t              dec;
    logic [ELEM_W-1:0] acc;
    logic [ELEM_W-1:0] fold_y;
    logic              fmt16_q;
    logic              is_max_q;

    fpred_decode u_decode (
        .funct6 (funct6),
        .sew    (sew),
        .dec    (dec)
    );

    fpred_ctrl #(
        .MAX_ELEM (MAX_ELEM),
        .VL_W     (VL_W),
        .IDX_W    (IDX_W)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .dec        (dec),
        .vm         (vm),
        .mask       (mask),
        .vl         (vl),
        .seed       (seed),
        .elem_valid (elem_valid),
        .fold_y     (fold_y),
        .elem_idx   (elem_idx),
        .acc_o      (acc),
        .fmt16_o    (fmt16_q),
        .is_max_o   (is_max_q),
        .busy       (busy),
        .done       (done),
        .illegal    (illegal),
        .unsup      (unsup),
        .wr_en      (wr_en),
        .vstart_clr (vstart_clr)
    );

    fpred_cmp u_cmp (
        .acc    (acc),
        .elem   (elem_data),
        .fmt16  (fmt16_q),
        .is_max (is_max_q),
        .pick   (fold_y)
    );

    assign result = acc;

endmodule

// File: tb/fp_vec_reduce_tb.sv
module fp_vec_reduce_tb;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_ELEM   = 32;
    localparam int VL_W       = 6;
    localparam int IDX_W      = 5;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                start = 1'b0;
    logic [5:0]          funct6 = '0;
    logic                vm = 1'b1;
    logic [1:0]          sew = 2'd2;
    logic [VL_W-1:0]     vl = '0;
    logic [MAX_ELEM-1:0] mask = '0;
    logic [31:0]         seed = '0;
    logic                elem_valid = 1'b0;
    logic [31:0]         elem_data = '0;
    logic [IDX_W-1:0]    elem_idx;
    logic                busy, done, illegal, unsup, wr_en, vstart_clr;
    logic [31:0]         result;

    int          vectors = 0;
    int          miscompares = 0;
    bit          finished = 1'b0;
    logic [31:0] ev [MAX_ELEM];
    logic [31:0] last_result;

    always #(CLK_PERIOD/2) clk = ~clk;

    fp_vec_reduce #(.MAX_ELEM(MAX_ELEM)) u_dut (
        .clk(clk), .rst(rst), .start(start), .funct6(funct6), .vm(vm), .sew(sew),
        .vl(vl), .mask(mask), .seed(seed), .elem_valid(elem_valid),
        .elem_data(elem_data), .elem_idx(elem_idx), .busy(busy), .done(done),
        .illegal(illegal), .unsup(unsup), .wr_en(wr_en), .vstart_clr(vstart_clr),
        .result(result)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] fit(input logic [31:0] v, input bit h);
        return h ? {16'h0, v[15:0]} : v;
    endfunction

    function automatic bit is_nan(input logic [31:0] v, input bit h);
        if (h) return (v[14:10] == 5'h1F) && (v[9:0] != 0);
        return (v[30:23] == 8'hFF) && (v[22:0] != 0);
    endfunction

    // true when a orders strictly below b, by sign then magnitude
    function automatic bit less_than(input logic [31:0] a, input logic [31:0] b, input bit h);
        bit sa, sb;
        logic [30:0] ma, mb;
        sa = h ? a[15] : a[31];
        sb = h ? b[15] : b[31];
        ma = h ? {16'h0, a[14:0]} : a[30:0];
        mb = h ? {16'h0, b[14:0]} : b[30:0];
        if (sa != sb) return sa;
        if (!sa) return ma < mb;
        return ma > mb;
    endfunction

    function automatic logic [31:0] ref_pick(input logic [31:0] a0, input logic [31:0] b0,
                                             input bit h, input bit mx);
        logic [31:0] a, b;
        a = fit(a0, h);
        b = fit(b0, h);
        if (is_nan(a, h) && is_nan(b, h)) return h ? 32'h0000_7E00 : 32'h7FC0_0000;
        if (is_nan(a, h)) return b;
        if (is_nan(b, h)) return a;
        if (mx) return less_than(a, b, h) ? b : a;
        return less_than(b, a, h) ? b : a;
    endfunction

    function automatic logic [31:0] gen_val();
        case ($urandom % 8)
            0: return 32'h0000_0000;
            1: return 32'h0000_8000;
            2: return 32'h8000_0000;
            3: return 32'h7FC0_0001;
            4: return 32'h1234_7D01;
            default: return $urandom;
        endcase
    endfunction

    task automatic run_op(input logic [5:0] f6, input bit vmb, input logic [1:0] sw,
                          input int len, input logic [31:0] msk, input logic [31:0] sd,
                          input string tag, input bit poke);
        bit known, widen, sum, e_ill, e_uns, e_wr, h, mx, vdrv;
        logic [31:0] e_res;
        int cnt, cyc;
        known = (f6 == 6'b000011) || (f6 == 6'b000001) || (f6 == 6'b000111) ||
                (f6 == 6'b000101) || (f6 == 6'b110011) || (f6 == 6'b110001);
        widen = (f6 == 6'b110011) || (f6 == 6'b110001);
        sum   = widen || (f6 == 6'b000011) || (f6 == 6'b000001);
        e_ill = !known || (sw == 2'd0) || (widen && sw == 2'd3);
        e_uns = !e_ill && (sum || sw == 2'd3);
        e_wr  = !e_ill && !e_uns && (len != 0);
        h     = (sw == 2'd1);
        mx    = (f6 == 6'b000111);
        e_res = fit(sd, h);
        for (int i = 0; i < len; i++)
            if (vmb || msk[i]) e_res = ref_pick(e_res, ev[i], h, mx);

        @(negedge clk);
        start = 1'b1; funct6 = f6; vm = vmb; sew = sw; vl = VL_W'(len); mask = msk; seed = sd;
        @(negedge clk);
        start = 1'b0;
        cnt = 0; cyc = 0;
        while (!done && cyc < 2000) begin
            vdrv = ($urandom % 4) != 0;
            chk(32'(elem_idx) == 32'(cnt), {tag, " R6 index order"}, 32'(elem_idx), 32'(cnt));
            elem_valid = vdrv;
            elem_data  = ev[elem_idx];
            @(negedge clk);
            if (vdrv) cnt++;
            cyc++;
        end
        elem_valid = 1'b0;
        chk(done, {tag, " R8 done seen"}, 32'(done), 1);
        chk(busy, {tag, " R9 busy in done cycle"}, 32'(busy), 1);
        chk(illegal == e_ill, {tag, " R1 R2 illegal flag"}, 32'(illegal), 32'(e_ill));
        chk(unsup == e_uns, {tag, " R3 unsup flag"}, 32'(unsup), 32'(e_uns));
        chk(wr_en == e_wr, {tag, " R4 R8 write strobe"}, 32'(wr_en), 32'(e_wr));
        chk(vstart_clr == e_wr, {tag, " R8 vstart clear"}, 32'(vstart_clr), 32'(e_wr));
        chk(cnt == (e_wr ? len : 0), {tag, " R6 elements consumed"}, 32'(cnt),
            32'(e_wr ? len : 0));
        if (e_wr) chk(result == e_res, {tag, " R7 result"}, result, e_res);
        last_result = result;
        if (poke) begin
            start = 1'b1; funct6 = 6'b000111; sew = 2'd2; vl = VL_W'(3); vm = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(!busy && !done, {tag, " R9 start in done cycle dropped"}, {busy, done}, 0);
            elem_valid = 1'b1;
            @(negedge clk);
            elem_valid = 1'b0;
            @(negedge clk);
            chk(!busy && !done && !wr_en, {tag, " R9 idle elem_valid ignored"},
                {busy, done, wr_en}, 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            miscompares++;
            vectors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < MAX_ELEM; i++) ev[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !wr_en, "R8 R9 reset state", {busy, done, wr_en}, 0);

        // directed max, 32-bit, then the start collision in the done cycle
        ev[0] = 32'h3F80_0000; ev[1] = 32'h4040_0000; ev[2] = 32'hC100_0000; ev[3] = 32'h4000_0000;
        run_op(6'b000111, 1'b1, 2'd2, 4, 0, 32'h0000_0000, "max32", 1'b1);
        chk(last_result == 32'h4040_0000, "R7 max32 value", last_result, 32'h4040_0000);

        // all elements inactive: seed comes back
        run_op(6'b000101, 1'b0, 2'd2, 8, 32'h0, 32'h4120_0000, "all masked", 1'b0);
        chk(last_result == 32'h4120_0000, "R6 all masked keeps seed", last_result, 32'h4120_0000);

        // 16-bit seed takes low half only
        run_op(6'b000111, 1'b0, 2'd1, 4, 32'h0, 32'hABCD_3C00, "seed16", 1'b0);
        chk(last_result == 32'h0000_3C00, "R5 seed16 sizing", last_result, 32'h0000_3C00);

        run_op(6'b000111, 1'b1, 2'd2, 0, 0, 32'h1, "zero length R4", 1'b0);
        run_op(6'b000111, 1'b1, 2'd0, 4, 0, 32'h1, "sew8 R2", 1'b0);
        run_op(6'b110011, 1'b1, 2'd3, 4, 0, 32'h1, "widen64 R2", 1'b0);
        run_op(6'b000000, 1'b1, 2'd2, 4, 0, 32'h1, "bad code R1", 1'b0);
        run_op(6'b111111, 1'b1, 2'd1, 0, 0, 32'h1, "bad code vl0 R1", 1'b0);
        run_op(6'b000011, 1'b1, 2'd2, 4, 0, 32'h1, "osum R3", 1'b0);
        run_op(6'b110001, 1'b1, 2'd1, 4, 0, 32'h1, "wusum16 R3", 1'b0);
        run_op(6'b000101, 1'b1, 2'd3, 4, 0, 32'h1, "min64 R3", 1'b0);
        run_op(6'b000001, 1'b1, 2'd2, 0, 0, 32'h1, "usum vl0 R3", 1'b0);

        // signed zeros
        ev[0] = 32'h0000_8000;
        run_op(6'b000101, 1'b1, 2'd1, 1, 0, 32'h0000_0000, "min zeros", 1'b0);
        chk(last_result == 32'h0000_8000, "R7 -0 below +0 min", last_result, 32'h0000_8000);
        ev[0] = 32'h0000_0000;
        run_op(6'b000111, 1'b1, 2'd2, 1, 0, 32'h8000_0000, "max zeros", 1'b0);
        chk(last_result == 32'h0000_0000, "R7 +0 above -0 max", last_result, 32'h0000_0000);

        // NaN handling
        ev[0] = 32'hC0A0_0000;
        run_op(6'b000111, 1'b1, 2'd2, 1, 0, 32'h7F80_0001, "nan seed", 1'b0);
        chk(last_result == 32'hC0A0_0000, "R7 nan vs number", last_result, 32'hC0A0_0000);
        ev[0] = 32'h7FFF_FFFF;
        run_op(6'b000101, 1'b1, 2'd2, 1, 0, 32'h7F80_0001, "two nans", 1'b0);
        chk(last_result == 32'h7FC0_0000, "R7 canonical nan 32", last_result, 32'h7FC0_0000);
        ev[0] = 32'h0000_FE01;
        run_op(6'b000111, 1'b1, 2'd1, 1, 0, 32'h0000_7C01, "two nans16", 1'b0);
        chk(last_result == 32'h0000_7E00, "R7 canonical nan 16", last_result, 32'h0000_7E00);

        // full length
        for (int i = 0; i < MAX_ELEM; i++) ev[i] = gen_val();
        run_op(6'b000101, 1'b1, 2'd1, MAX_ELEM, 0, gen_val(), "full length R6", 1'b0);

        // random mix
        for (int t = 0; t < 80; t++) begin
            logic [5:0] f6;
            logic [1:0] sw;
            int r;
            r = $urandom % 12;
            if (r < 5)       f6 = 6'b000111;
            else if (r < 10) f6 = 6'b000101;
            else if (r == 10) f6 = 6'b110001;
            else             f6 = 6'($urandom);
            sw = (($urandom % 8) == 0) ? 2'($urandom) : (($urandom % 2) ? 2'd1 : 2'd2);
            for (int i = 0; i < MAX_ELEM; i++) ev[i] = gen_val();
            run_op(f6, 1'($urandom), sw, int'($urandom % (MAX_ELEM + 1)), $urandom,
                   gen_val(), "random", (t % 10) == 0);
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule